// File: doc/BRIEF.md
# Mismatch Burst Guard for an RF Power Stage

This block sits between a logic-level on/off modulation request and the gate-bias enable of an RF power amplifier. A separate analog comparator flags a load mismatch when reflected power is too high compared with forward power. The comparator trips at a threshold equal to a 2:1 standing-wave ratio. This block receives that flag only as a single digital input.

Each time the stage is switched on, the guard ignores the mismatch flag for a fixed blanking window. At the end of the window it samples the flag once. If the flag is clear, the bias stays on for as long as the request stays active. If the flag is set, the bias is forced off for a long hold-off period. After the hold-off, a new blanking window starts if the request is still active.

With a fault that does not go away, the result is a train of full-power bursts of 200 µs at roughly a 9% duty cycle. These bursts let a hard-to-ignite load strike without overheating the transistors. Once the load becomes matched, the next sample finds the flag clear and the stage runs continuously. Both timer lengths are derived from a clock-frequency parameter.

Top module: `mismatch_burst_guard`

## Requirements
- R1: While reset is asserted, and after it is released until the request becomes active, `biasEn` and `holdOff` are both low.
- R2: `ttlIn` and `faultIn` each pass through a two-flop synchronizer. A rise of `ttlIn` set up before clock edge k raises `biasEn` after edge k+2.
- R3: For the first BLANK_CYC cycles after the bias turns on, the state of `faultIn` has no effect, and `biasEn` stays high as long as the request is active.
- R4: In the cycle where the blanking window ends, the synchronized fault flag is sampled. If it is high, the bias drops and `holdOff` rises on the same edge.
- R5: While `holdOff` is high, `biasEn` is low whatever `ttlIn` does. `holdOff` lasts exactly HOLD_CYC cycles.
- R6: If the sampled fault flag is low, no protection starts. `biasEn` stays high while the request is active, and later changes of `faultIn` are ignored.
- R7: When the hold-off ends with the request still active, a fresh blanking window starts. A persistent fault therefore gives repeating bursts of BLANK_CYC cycles on and HOLD_CYC cycles off.
- R8: When the synchronized request goes low outside a hold-off, `biasEn` falls on the next edge. The blanking count restarts from its full length on the next turn-on.
- R9: When the hold-off ends with the request inactive, the block returns to idle with `biasEn` low.
- R10: BLANK_CYC = CLK_FREQ_HZ/1e6 × BLANK_US and HOLD_CYC = CLK_FREQ_HZ/1e6 × HOLD_US (defaults 200 µs and 2000 µs). A clock below 1 MHz is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, frequency given by CLK_FREQ_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| ttlIn | input | 1 | Asynchronous on/off modulation request, high = on |
| faultIn | input | 1 | Asynchronous mismatch flag from the comparator, high = fault |
| biasEn | output | 1 | Gate-bias enable for the power stage |
| holdOff | output | 1 | High while the forced-off period runs |

## Verification
The hardest cases to reach are the edges of each timer window. One is a fault that sits in the flag only during blanking and clears exactly before the sample. Another is a request that drops and returns partway through a blanking window. A third is a request that goes away during a hold-off, so that the hold-off expires into idle rather than into a new burst. The bench reaches all three with a cycle-counted stimulus sequence. It runs the block at a 1 MHz setting, so one window lasts 200 cycles and the other 2000. A cycle-by-cycle expectation built from the requirements is compared on every clock.

// File: rtl/mbg_pkg.sv
package mbg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_RUN   = 2'd2,
    ST_HOLD  = 2'd3
  } guardState_t;

  // Strobes from the control FSM to the timing datapath.
  typedef struct packed {
    logic loadBlank;
    logic loadHold;
  } timerCmd_t;

endpackage

// File: rtl/mbg_sync.sv
module mbg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/mbg_timer.sv
module mbg_timer
  import mbg_pkg::*;
#(
  parameter int BLANK_CYC = 200,
  parameter int HOLD_CYC  = 2000
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCmd_t cmd,
  output logic      timerDone
);

  localparam int MAX_CYC = (BLANK_CYC > HOLD_CYC) ? BLANK_CYC : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] BLANK_LOAD = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD  = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                remain <= '0;
    else if (cmd.loadBlank)   remain <= BLANK_LOAD;
    else if (cmd.loadHold)    remain <= HOLD_LOAD;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign timerDone = (remain == '0);

endmodule

// File: rtl/mbg_ctrl.sv
module mbg_ctrl
  import mbg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ttlSync,
  input  logic      faultSync,
  input  logic      timerDone,
  output timerCmd_t cmd,
  output logic      biasEn,
  output logic      holdOff
);

  guardState_t state, stateNext;

  always_comb begin
    stateNext     = state;
    cmd.loadBlank = 1'b0;
    cmd.loadHold  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ttlSync) begin
          stateNext     = ST_BLANK;
          cmd.loadBlank = 1'b1;
        end
      end
      ST_BLANK: begin
        if (!ttlSync) begin
          stateNext = ST_IDLE;
        end else if (timerDone) begin
          if (faultSync) begin
            stateNext    = ST_HOLD;
            cmd.loadHold = 1'b1;
          end else begin
            stateNext = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (!ttlSync) stateNext = ST_IDLE;
      end
      ST_HOLD: begin
        if (timerDone) begin
          if (ttlSync) begin
            stateNext     = ST_BLANK;
            cmd.loadBlank = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign biasEn  = (state == ST_BLANK) || (state == ST_RUN);
  assign holdOff = (state == ST_HOLD);

endmodule

// File: rtl/mismatch_burst_guard.sv
module mismatch_burst_guard
  import mbg_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int BLANK_US    = 200,
  parameter int HOLD_US     = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic ttlIn,
  input  logic faultIn,
  output logic biasEn,
  output logic holdOff
);

  localparam int TICKS_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int BLANK_CYC    = TICKS_PER_US * BLANK_US;
  localparam int HOLD_CYC     = TICKS_PER_US * HOLD_US;

  generate
    if (CLK_FREQ_HZ < 1_000_000) begin : g_bad_clock
      $error("mismatch_burst_guard: CLK_FREQ_HZ must be at least 1 MHz");
    end
  endgenerate

  logic [1:0] syncBus;
  logic       ttlSync;
  logic       faultSync;
  logic       timerDone;
  timerCmd_t  cmd;

  mbg_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({faultIn, ttlIn}),
    .syncOut (syncBus)
  );

  assign ttlSync   = syncBus[0];
  assign faultSync = syncBus[1];

  mbg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ttlSync   (ttlSync),
    .faultSync (faultSync),
    .timerDone (timerDone),
    .cmd       (cmd),
    .biasEn    (biasEn),
    .holdOff   (holdOff)
  );

  mbg_timer #(.BLANK_CYC(BLANK_CYC), .HOLD_CYC(HOLD_CYC)) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .timerDone (timerDone)
  );

endmodule

// File: rtl/mbg_checker.sv
module mbg_checker #(
  parameter int BLANK_CYC = 200,
  parameter int HOLD_CYC  = 2000
) (
  input logic clk,
  input logic rstN,
  input logic ttlSync,
  input logic faultSync,
  input logic biasEn,
  input logic holdOff
);

  int holdCnt;
  int burstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= 0;
      burstCnt <= 0;
    end else begin
      holdCnt  <= holdOff ? holdCnt + 1 : 0;
      burstCnt <= biasEn  ? burstCnt + 1 : 0;
    end
  end

  // R5: forced-off period excludes the bias
  p_hold_blocks_bias_r5: assert property (@(posedge clk) disable iff (!rstN)
    holdOff |-> !biasEn);

  // R5 / R10: hold-off lasts exactly HOLD_CYC cycles
  p_hold_length_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdOff) |-> (holdCnt == HOLD_CYC));

  // R3 / R4: hold-off only follows a full blanking burst with the fault sampled high
  p_hold_after_blank_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdOff) |-> (burstCnt == BLANK_CYC) && $past(faultSync));

  // R8: an inactive synchronized request leaves the bias off on the next edge
  p_request_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ttlSync |=> !biasEn);

  // R2: the bias only rises after the synchronized request is seen
  p_sync_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(biasEn) |-> $past(ttlSync));

  // R7: hold-off ending with an active request re-enters a burst
  p_restrike_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdOff) && $past(ttlSync) |-> biasEn);

endmodule

bind mismatch_burst_guard mbg_checker #(
  .BLANK_CYC (BLANK_CYC),
  .HOLD_CYC  (HOLD_CYC)
) u_mbg_checker (
  .clk       (clk),
  .rstN      (rstN),
  .ttlSync   (ttlSync),
  .faultSync (faultSync),
  .biasEn    (biasEn),
  .holdOff   (holdOff)
);

// File: tb/tb_mismatch_burst_guard.sv
module tb_mismatch_burst_guard;

  localparam int CLK_HZ    = 1_000_000;
  localparam int BLANK_US  = 200;
  localparam int HOLD_US   = 2000;
  localparam int BLANK_CYC = (CLK_HZ / 1_000_000) * BLANK_US;
  localparam int HOLD_CYC  = (CLK_HZ / 1_000_000) * HOLD_US;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ttlDrv = 1'b0;
  logic faultDrv = 1'b0;
  logic biasEn, holdOff;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mismatch_burst_guard #(
    .CLK_FREQ_HZ (CLK_HZ),
    .BLANK_US    (BLANK_US),
    .HOLD_US     (HOLD_US)
  ) dut (
    .clk     (clk),
    .rstN    (rstN),
    .ttlIn   (ttlDrv),
    .faultIn (faultDrv),
    .biasEn  (biasEn),
    .holdOff (holdOff)
  );

  // Scoreboard queues: expected {biasEn, holdOff} and the requirement it exercises.
  logic [1:0] expQ[$];
  string      tagQ[$];

  // Expectation builder, from the requirements; reads only bench-driven inputs.
  typedef enum int {M_IDLE, M_BLANK, M_RUN, M_HOLD} mState_t;
  mState_t mst = M_IDLE;
  int  mcnt = 0;
  bit  ms1 = 0, ms2 = 0, mf1 = 0, mf2 = 0;

  always @(posedge clk) begin
    logic [1:0] e;
    string tag;
    if (!rstN) begin
      ms1 = 0; ms2 = 0; mf1 = 0; mf2 = 0;
      mst = M_IDLE; mcnt = 0;
      tag = "R1";
    end else begin
      bit t, f;
      t = ms2; f = mf2;
      tag = "R8";
      case (mst)
        M_IDLE: begin
          if (t) begin mst = M_BLANK; mcnt = BLANK_CYC; tag = "R2"; end
          else if (ttlDrv || ms1) tag = "R2";
          else tag = "R1";
        end
        M_BLANK: begin
          if (!t) begin mst = M_IDLE; tag = "R8"; end
          else begin
            mcnt--;
            tag = (mcnt == 1) ? "R10" : "R3";
            if (mcnt == 0) begin
              if (f) begin mst = M_HOLD; mcnt = HOLD_CYC; tag = "R4"; end
              else   begin mst = M_RUN; tag = "R6"; end
            end
          end
        end
        M_RUN: begin
          if (!t) begin mst = M_IDLE; tag = "R8"; end
          else tag = "R6";
        end
        M_HOLD: begin
          mcnt--;
          tag = (mcnt == 1) ? "R10" : "R5";
          if (mcnt == 0) begin
            if (t) begin mst = M_BLANK; mcnt = BLANK_CYC; tag = "R7"; end
            else   begin mst = M_IDLE; tag = "R9"; end
          end
        end
        default: mst = M_IDLE;
      endcase
      ms2 = ms1; ms1 = ttlDrv;
      mf2 = mf1; mf1 = faultDrv;
    end
    e[1] = (mst == M_BLANK) || (mst == M_RUN);
    e[0] = (mst == M_HOLD);
    expQ.push_back(e);
    tagQ.push_back(tag);
  end

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [1:0] e;
      string tag;
      e = expQ.pop_front();
      tag = tagQ.pop_front();
      checks++;
      if ({biasEn, holdOff} !== e) begin
        fails++;
        $display("FAIL %s at %0t: {biasEn,holdOff} actual=%b expected=%b",
                 tag, $time, {biasEn, holdOff}, e);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    // R1: reset state
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(10);

    // R2, R6: clean turn-on, then a late fault is ignored
    ttlDrv = 1'b1;
    waitCyc(400);
    faultDrv = 1'b1;
    waitCyc(100);
    faultDrv = 1'b0;
    ttlDrv = 1'b0;            // R8: drop
    waitCyc(20);

    // R3: fault only inside blanking, clear before the sample
    ttlDrv = 1'b1;
    waitCyc(20);
    faultDrv = 1'b1;
    waitCyc(150);
    faultDrv = 1'b0;
    waitCyc(200);
    ttlDrv = 1'b0;
    waitCyc(20);

    // R4, R5, R7, R10: persistent fault, two full bursts then recovery
    faultDrv = 1'b1;
    ttlDrv = 1'b1;
    waitCyc(2 * (BLANK_CYC + HOLD_CYC) + 100);
    faultDrv = 1'b0;          // next sample sees a clean load: R6
    waitCyc(HOLD_CYC + BLANK_CYC + 300);
    ttlDrv = 1'b0;
    waitCyc(20);

    // R8: request drops mid-blank, then returns for a fresh full window
    faultDrv = 1'b1;
    ttlDrv = 1'b1;
    waitCyc(50);
    ttlDrv = 1'b0;
    waitCyc(10);
    ttlDrv = 1'b1;
    waitCyc(BLANK_CYC + 100);
    // R5: toggle request during hold-off, R9: leave it low at expiry
    ttlDrv = 1'b0;
    waitCyc(300);
    ttlDrv = 1'b1;
    waitCyc(300);
    ttlDrv = 1'b0;
    faultDrv = 1'b0;
    waitCyc(HOLD_CYC);

    // R1: reset mid-operation returns everything low
    ttlDrv = 1'b1;
    waitCyc(100);
    rstN = 1'b0;
    waitCyc(5);
    ttlDrv = 1'b0;
    rstN = 1'b1;
    waitCyc(10);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule